// File: doc/BRIEF.md
# Scratchpad Replica Write Coalescer

This block sits between the write port of a data scratchpad and the cache that keeps a duplicate copy of every scratchpad line. The duplicate exists so that a line found corrupt by a cheap detection code can be restored. Without this block, every scratchpad store would also cost one cache access. The coalescer instead holds one line-sized staging entry of eight 32-bit words. Stores that fall into the staged line are merged into it in place. The cache is only touched when a store moves to a different line, or when software asks for the staged contents to be pushed out.

A push to the cache carries the line address, all eight data words and an eight-bit mask. The mask marks the words that were actually stored since the entry was filled, so the cache leaves every other word of its copy untouched. The push uses a valid/ready handshake. While a push is outstanding, the block stops accepting stores. The cache reports through one input whether it already holds a copy of the pushed line. The block turns that bit into an allocate request, which tells the cache it must pick a fresh line before the push completes.

Top module: `replica_coalesce_buf`

## Requirements
- R1: After reset the staging entry is empty: `wrReady` is 1 and `wbValid` and `wbAlloc` are 0.
- R2: A store into an empty entry is accepted in the cycle it is presented and causes no push. The entry takes the store's line address, which is word address bits [ADDR_W-1:3].
- R3: A store whose line address equals the staged line is accepted at once. It replaces the addressed word (word index = address bits [2:0]) and causes no push.
- R4: A store to a different line while the entry is occupied is held off (`wrReady` 0). The old line is pushed first, and once that push is taken the store is accepted into the emptied entry. Each eviction produces exactly one push.
- R5: `wbMask` bit i is 1 exactly when word i of the pushed line was stored since the entry was filled. Words whose mask bit is 0 leave the cache copy unchanged.
- R6: While `wbValid` is 1 and `wbReady` is 0, `wbValid`, `wbLineAddr`, `wbData` and `wbMask` hold steady and no store is accepted.
- R7: A `flushReq` pulse while the entry is occupied pushes the line and then leaves the entry empty. The next store is then accepted without a push.
- R8: A `flushReq` pulse while the entry is empty and no store is accepted causes no push.
- R9: During a push, `wbAlloc` is the inverse of `cacheHit`, so a new cache line is requested only when no copy of the line exists.
- R10: A store accepted in the same cycle as a `flushReq` is part of the line that the flush pushes, both for a store to the staged line and for a store into an empty entry.
- R11: Over any sequence of stores followed by a flush, the cache copy that the pushes build equals the last value stored at every address. The number of pushes equals the number of line changes plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Scratchpad store present |
| wrReady | output | 1 | Store accepted this cycle when high with wrValid |
| wrAddr | input | ADDR_W | Word address of the store |
| wrData | input | WORD_W | Store data |
| flushReq | input | 1 | Push the staged line and empty the entry |
| wbValid | output | 1 | Push to the cache pending |
| wbReady | input | 1 | Cache takes the push |
| wbLineAddr | output | ADDR_W-3 | Line address of the pushed line |
| wbData | output | 8*WORD_W | All eight words; word i at bits [32i+31:32i] |
| wbMask | output | 8 | Per-word write enable for the push |
| cacheHit | input | 1 | Cache already holds a copy of wbLineAddr |
| wbAlloc | output | 1 | Cache must allocate a line for this push |

## Verification
Two functions can act in one clock: a flush request and the acceptance of a store, which may either merge into the staged line or fill an empty entry. The bench drives `flushReq` on the very edge where such a store is accepted. It then checks that the resulting push carries the new word, with its mask bit set beside the earlier ones. A long sweep with the cache stalled on a repeating pattern also lets evictions meet back-pressure. The rebuilt cache copy and the push count are compared against values the bench derives from the store sequence.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  // Strobes from the control to the staging datapath
  typedef struct packed {
    logic alloc;   // fill empty entry with the accepted store
    logic update;  // merge accepted store into the staged line
    logic clear;   // push taken: drop the word mask
  } rcbStrobe_t;
endpackage

// File: rtl/rcb_datapath.sv
module rcb_datapath
  import rcb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rcbStrobe_t              strobe,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WORD_W-1:0]       wrData,
  output logic                    lineHit,
  output logic [ADDR_W-$clog2(WORDS)-1:0] wbLineAddr,
  output logic [WORDS*WORD_W-1:0] wbData,
  output logic [WORDS-1:0]        wbMask
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int LINE_W = ADDR_W - IDX_W;

  logic [LINE_W-1:0] tagQ;
  logic [LINE_W-1:0] wrLine;
  logic [IDX_W-1:0]  wrIdx;

  assign wrLine = wrAddr[ADDR_W-1:IDX_W];
  assign wrIdx  = wrAddr[IDX_W-1:0];
  assign lineHit = (tagQ == wrLine);
  assign wbLineAddr = tagQ;

  always_ff @(posedge clk) begin
    if (!rstN) tagQ <= '0;
    else if (strobe.alloc) tagQ <= wrLine;
  end

  for (genvar i = 0; i < WORDS; i++) begin : gWord
    logic [WORD_W-1:0] dataQ;
    logic              maskQ;
    logic              sel;
    assign sel = (wrIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ <= '0;
        maskQ <= 1'b0;
      end else begin
        if ((strobe.alloc || strobe.update) && sel) dataQ <= wrData;
        if (strobe.clear) maskQ <= 1'b0;
        else if (strobe.alloc) maskQ <= sel;
        else if (strobe.update && sel) maskQ <= 1'b1;
      end
    end

    assign wbData[i*WORD_W +: WORD_W] = dataQ;
    assign wbMask[i] = maskQ;
  end
endmodule

// File: rtl/rcb_control.sv
module rcb_control
  import rcb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic       lineHit,
  input  logic       flushReq,
  input  logic       wbReady,
  output logic       wrReady,
  output logic       wbValid,
  output rcbStrobe_t strobe
);
  logic bufValidQ, evictPendQ, flushPendQ;
  logic hit, wrFire, wbFire;

  always_comb begin
    hit     = bufValidQ && lineHit;
    wbValid = evictPendQ || flushPendQ;
    wrReady = !wbValid && (!bufValidQ || hit);
    wrFire  = wrValid && wrReady;
    wbFire  = wbValid && wbReady;
    strobe.alloc  = wrFire && !bufValidQ;
    strobe.update = wrFire && bufValidQ;
    strobe.clear  = wbFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValidQ  <= 1'b0;
      evictPendQ <= 1'b0;
      flushPendQ <= 1'b0;
    end else if (wbFire) begin
      bufValidQ  <= 1'b0;
      evictPendQ <= 1'b0;
      flushPendQ <= 1'b0;
    end else if (!wbValid) begin
      if (strobe.alloc) bufValidQ <= 1'b1;
      evictPendQ <= wrValid && bufValidQ && !hit;
      flushPendQ <= flushReq && (bufValidQ || wrFire);
    end
  end
endmodule

// File: rtl/replica_coalesce_buf.sv
module replica_coalesce_buf
  import rcb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrValid,
  output logic                    wrReady,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [WORD_W-1:0]       wrData,
  input  logic                    flushReq,
  output logic                    wbValid,
  input  logic                    wbReady,
  output logic [ADDR_W-$clog2(WORDS)-1:0] wbLineAddr,
  output logic [WORDS*WORD_W-1:0] wbData,
  output logic [WORDS-1:0]        wbMask,
  input  logic                    cacheHit,
  output logic                    wbAlloc
);
  rcbStrobe_t strobe;
  logic lineHit;

  rcb_control uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .lineHit(lineHit),
    .flushReq(flushReq), .wbReady(wbReady), .wrReady(wrReady),
    .wbValid(wbValid), .strobe(strobe)
  );

  rcb_datapath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .wrData(wrData), .lineHit(lineHit), .wbLineAddr(wbLineAddr),
    .wbData(wbData), .wbMask(wbMask)
  );

  assign wbAlloc = wbValid && !cacheHit;
endmodule

// File: rtl/rcb_checker.sv
module rcb_checker #(
  parameter int LINE_W = 13,
  parameter int DATA_W = 256,
  parameter int WORDS  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrReady,
  input logic              wbValid,
  input logic              wbReady,
  input logic [LINE_W-1:0] wbLineAddr,
  input logic [DATA_W-1:0] wbData,
  input logic [WORDS-1:0]  wbMask
);
  // R6: no store is taken while a push is outstanding
  a_r6_no_store_during_push: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !wrReady);

  // R6: a stalled push keeps its contents
  a_r6_push_held: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbLineAddr) &&
                               $stable(wbMask) && $stable(wbData)));

  // R5: a pushed line always carries at least one written word
  a_r5_mask_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbMask != '0));

  // R4: one push per eviction, entry empty afterwards
  a_r4_single_push: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && wbReady) |=> !wbValid);
endmodule

bind replica_coalesce_buf rcb_checker #(
  .LINE_W(ADDR_W - $clog2(WORDS)), .DATA_W(WORDS*WORD_W), .WORDS(WORDS)
) uChk (
  .clk(clk), .rstN(rstN), .wrReady(wrReady), .wbValid(wbValid),
  .wbReady(wbReady), .wbLineAddr(wbLineAddr), .wbData(wbData), .wbMask(wbMask)
);

// File: tb/sim_replica_coalesce_buf.sv
`timescale 1ns/1ps
module sim_replica_coalesce_buf;
  localparam int ADDR_W = 10;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int LINE_W = ADDR_W - 3;
  localparam int NADDR  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic wrReady;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [WORD_W-1:0] wrData = '0;
  logic flushReq = 1'b0;
  logic wbValid;
  logic wbReady;
  logic [LINE_W-1:0] wbLineAddr;
  logic [WORDS*WORD_W-1:0] wbData;
  logic [WORDS-1:0] wbMask;
  logic cacheHit;
  logic wbAlloc;

  int tests = 0;
  int fails = 0;
  int wbCount = 0;
  int cyc = 0;
  bit holdLow = 1'b0;
  bit stallMode = 1'b0;
  logic [LINE_W-1:0] lastTag;
  logic [WORDS-1:0] lastMask;
  logic [WORDS*WORD_W-1:0] lastData;
  logic [WORD_W-1:0] shadow [NADDR];
  logic [WORD_W-1:0] golden [NADDR];

  always #10 clk = ~clk;  // 50 MHz

  // bench model of the cache: a copy exists for odd line addresses
  assign cacheHit = wbLineAddr[0];

  replica_coalesce_buf #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .flushReq(flushReq),
    .wbValid(wbValid), .wbReady(wbReady), .wbLineAddr(wbLineAddr),
    .wbData(wbData), .wbMask(wbMask), .cacheHit(cacheHit), .wbAlloc(wbAlloc)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cache back-pressure
  always @(negedge clk) begin
    cyc++;
    wbReady = holdLow ? 1'b0 : (stallMode ? ((cyc % 3) != 0) : 1'b1);
  end

  // cache side: take pushes, rebuild the copy, check allocate (R9)
  always @(negedge clk) begin
    #5;
    if (rstN && wbValid && wbReady) begin
      wbCount++;
      lastTag = wbLineAddr;
      lastMask = wbMask;
      lastData = wbData;
      for (int w = 0; w < WORDS; w++)
        if (wbMask[w]) shadow[{wbLineAddr, 3'(w)}] = wbData[w*WORD_W +: WORD_W];
      check(wbAlloc === !cacheHit, "R9 allocate", {63'd0, wbAlloc}, {63'd0, !cacheHit});
    end
  end

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    wrAddr = a;
    wrData = d;
    wrValid = 1'b1;
    forever begin
      #2;
      if (wrReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    wrValid = 1'b0;
  endtask

  task automatic flushPulse();
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    int expWb;
    bit curValid;
    logic [LINE_W-1:0] curLine;
    for (int a = 0; a < NADDR; a++) begin
      shadow[a] = 32'hDEAD0000 | a;
      golden[a] = 32'hDEAD0000 | a;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    check(wrReady === 1'b1, "R1 wrReady", {63'd0, wrReady}, 64'd1);
    check(wbValid === 1'b0, "R1 wbValid", {63'd0, wbValid}, 64'd0);
    check(wbAlloc === 1'b0, "R1 wbAlloc", {63'd0, wbAlloc}, 64'd0);
    @(negedge clk);

    // R2 first store allocates without a push (line 1 word 0)
    doWrite(10'h008, 32'hA0A0_0001);
    repeat (3) @(negedge clk);
    check(wbCount == 0, "R2 no push on first store", 64'(wbCount), 64'd0);

    // R3 hits merge in place (line 1 words 3 and 7)
    doWrite(10'h00B, 32'hB0B0_0003);
    doWrite(10'h00F, 32'hC0C0_0007);
    repeat (3) @(negedge clk);
    check(wbCount == 0, "R3 no push on hits", 64'(wbCount), 64'd0);

    // R6 miss under stalled cache: store held, push held
    holdLow = 1'b1;
    wrAddr = 10'h020; wrData = 32'hD0D0_0000; wrValid = 1'b1;
    repeat (5) begin
      @(negedge clk);
      #2;
      check(wrReady === 1'b0, "R6 store held during push", {63'd0, wrReady}, 64'd0);
    end
    check(wbValid === 1'b1, "R6 push pending", {63'd0, wbValid}, 64'd1);
    check(wbCount == 0, "R6 push not taken while stalled", 64'(wbCount), 64'd0);
    holdLow = 1'b0;
    doWrite(10'h020, 32'hD0D0_0000);
    repeat (3) @(negedge clk);

    // R4 eviction pushed the old line once
    check(wbCount == 1, "R4 one push on miss", 64'(wbCount), 64'd1);
    check(lastTag == 7'd1, "R4 pushed line", 64'(lastTag), 64'd1);
    check(lastData[0 +: 32] == 32'hA0A0_0001, "R4 word0", 64'(lastData[0 +: 32]), 64'hA0A0_0001);
    check(lastData[96 +: 32] == 32'hB0B0_0003, "R3 word3 merged", 64'(lastData[96 +: 32]), 64'hB0B0_0003);
    check(lastData[224 +: 32] == 32'hC0C0_0007, "R3 word7 merged", 64'(lastData[224 +: 32]), 64'hC0C0_0007);
    // R5 mask marks words 0,3,7
    check(lastMask == 8'b1000_1001, "R5 mask", 64'(lastMask), 64'h89);

    // R7 flush pushes line 4 and empties the entry
    flushPulse();
    check(wbCount == 2, "R7 flush push", 64'(wbCount), 64'd2);
    check(lastTag == 7'd4 && lastMask == 8'b0000_0001, "R7 flushed line",
          {49'd0, lastTag, lastMask}, {49'd0, 7'd4, 8'h01});
    doWrite(10'h021, 32'hE0E0_0001);
    repeat (3) @(negedge clk);
    check(wbCount == 2, "R7 store after flush no push", 64'(wbCount), 64'd2);
    flushPulse();
    check(lastMask == 8'b0000_0010, "R7 entry was empty after flush", 64'(lastMask), 64'h02);

    // R8 flush on empty entry
    flushPulse();
    check(wbCount == 3, "R8 no push when empty", 64'(wbCount), 64'd3);

    // R10 flush in the same cycle as a merging store
    doWrite(10'h030, 32'hF0F0_0000);
    wrAddr = 10'h035; wrData = 32'hF0F0_0005; wrValid = 1'b1; flushReq = 1'b1;
    #2;
    check(wrReady === 1'b1, "R10 hit accepted with flush", {63'd0, wrReady}, 64'd1);
    @(negedge clk);
    wrValid = 1'b0; flushReq = 1'b0;
    repeat (6) @(negedge clk);
    check(wbCount == 4, "R10 flush push", 64'(wbCount), 64'd4);
    check(lastMask == 8'b0010_0001, "R10 mask includes same-cycle store", 64'(lastMask), 64'h21);
    check(lastData[160 +: 32] == 32'hF0F0_0005, "R10 word5", 64'(lastData[160 +: 32]), 64'hF0F0_0005);

    // R10 flush in the same cycle as a store into the empty entry
    wrAddr = 10'h042; wrData = 32'h1234_5678; wrValid = 1'b1; flushReq = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; flushReq = 1'b0;
    repeat (6) @(negedge clk);
    check(wbCount == 5 && lastTag == 7'd8 && lastMask == 8'b0000_0100,
          "R10 allocating store flushed", {41'd0, 8'(wbCount), lastTag, lastMask},
          {41'd0, 8'd5, 7'd8, 8'h04});

    // R11 sweep with back-pressure
    for (int a = 0; a < NADDR; a++) begin
      shadow[a] = 32'hDEAD0000 | a;
      golden[a] = 32'hDEAD0000 | a;
    end
    stallMode = 1'b1;
    base = wbCount;
    expWb = 0;
    curValid = 1'b0;
    curLine = '0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int l = 0; l < (pass == 0 ? 128 : 64); l++) begin
        logic [LINE_W-1:0] ln;
        ln = 7'((pass == 0) ? (l * 5) % 128 : (l * 7) % 128);
        for (int k = 0; k <= l % 8; k++) begin
          logic [ADDR_W-1:0] a;
          logic [WORD_W-1:0] d;
          a = {ln, 3'((k * 3 + l) % 8)};
          d = 32'h1000_0000 + (pass << 20) + (l << 8) + k;
          if (curValid && curLine != ln) expWb++;
          curValid = 1'b1;
          curLine = ln;
          golden[a] = d;
          doWrite(a, d);
        end
      end
    end
    if (curValid) expWb++;
    flushPulse();
    stallMode = 1'b0;
    repeat (6) @(negedge clk);
    check(wbCount - base == expWb, "R11 push count", 64'(wbCount - base), 64'(expWb));
    begin
      int bad;
      int firstBad;
      bad = 0;
      firstBad = 0;
      for (int a = 0; a < NADDR; a++)
        if (shadow[a] !== golden[a]) begin
          if (bad == 0) firstBad = a;
          bad++;
        end
      check(bad == 0, "R11 replica image", 64'(shadow[firstBad]), 64'(golden[firstBad]));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule